// File: doc/BRIEF.md
# DMA Interrupt Status, Mask and Clear Aggregator

This block gathers the completion and fault events of a DMA transfer/event channel pair into one interrupt. Each event source delivers a single-cycle pulse. The pulse sets a sticky bit in a status register, and the bit stays set until software writes a one to the matching position of a separate clear register. An enable register masks the status, and the cause is status AND enable.

A 4-bit mode field in a control register picks the signalling style. With mode bit 0 set, a wired level interrupt stays high for as long as any cause bit remains. With bit 0 clear, the block emits a one-cycle message pulse each time the cause goes from zero to nonzero. A separate output flags that the cause holds at least one fault bit rather than only the completion bit. Software reaches the registers through a simple 16-bit register bus. A read returns its data with a valid strobe one cycle after the request.

The output generator is a four-state machine:
- QUIET: no cause.
- LEVEL: the wired interrupt is driven.
- FIRE: the message pulse cycle.
- HOLD: the cause persists in message mode with no further pulse.

Its transitions are:
- QUIET->LEVEL: a cause appears in wired mode.
- QUIET->FIRE: a cause appears in message mode.
- FIRE->HOLD: the cause persists in message mode.
- LEVEL->HOLD: the mode switches to message while a cause is held.
- FIRE->LEVEL and HOLD->LEVEL: the mode switches to wired while a cause is held.
- HOLD->HOLD: the cause persists.
- Any state to QUIET: the cause falls to zero.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset the status and enable registers read 0, the control register reads 0x0001 (wired mode), and irq_level, msg_pulse and err_active are low.
- R2: A pulse on src_pulse[0..5] sets status bit 0, 1, 9, 10, 11 or 14 respectively (0 = completion, 1 = event write-response fault, 9 = descriptor read fault, 10 = data read fault, 11 = data write fault, 14 = invalid descriptor). The bit stays set until it is cleared.
- R3: A write to the clear register (offset 0x108) clears each status bit written as one and leaves bits written as zero unchanged. The clear register reads as zero.
- R4: When a source pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: The enable register (offset 0x110) stores only bits 0, 1, 9, 10, 11 and 14. Status (offset 0x100) bits at other positions always read zero.
- R6: In wired mode, irq_level is high in a cycle exactly when the cause (status AND enable) was nonzero in the previous cycle. It therefore rises two clock edges after the source pulse and falls two edges after the clearing write.
- R7: In message mode (control bit 0 = 0), msg_pulse is high for exactly one cycle, two edges after the cause goes from zero to nonzero. It stays low while the cause remains nonzero, and irq_level stays low.
- R8: err_active is high in a cycle exactly when the previous cycle's cause held any of bits 1, 9, 10, 11 or 14. The completion bit alone does not raise it.
- R9: The control register is at offset 0x004. Its low 4 bits are stored and bit 0 selects wired mode. Its upper bits read zero.
- R10: A read returns data with rsp_valid high in the cycle after the request. An unmapped offset reads as zero.
- R11: Status bits latch whether or not they are enabled. A disabled bit drives neither interrupt output nor err_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 6 | Single-cycle event pulses, mapped to status bits 0, 1, 9, 10, 11, 14 |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Register byte offset |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 16 | Read data |
| irq_level | output | 1 | Wired level interrupt |
| msg_pulse | output | 1 | Message-style one-cycle interrupt pulse |
| err_active | output | 1 | Cause holds a fault bit |

## Verification
The hardest case to reach from the ports is a source pulse landing in the very cycle that a clear write to the same bit is accepted. The stimulus drives the pulse and the bus write at the same falling edge and then reads status back.

A second hard case is a new cause arriving while an earlier one is still held in message mode, which must not produce a second pulse. The bench reaches it by stacking a second source pulse before any clear and counting msg_pulse cycles over a window. It then clears everything and raises a fresh cause to show that the pulse returns.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int STAT_W  = 16;
    localparam int REG_W   = STAT_W;
    localparam int NUM_SRC = 6;
    localparam int MODE_W  = 4;
    localparam int OFS_W   = 12;

    // Source index -> status bit position; the positions are decoded by software.
    localparam int SRC_POS [NUM_SRC] = '{0, 1, 9, 10, 11, 14};

    localparam logic [STAT_W-1:0] LIVE_MASK  = 16'h4E03;
    localparam logic [STAT_W-1:0] FAULT_MASK = 16'h4E02;

    localparam logic [OFS_W-1:0] OFS_MODE  = 12'h004;
    localparam logic [OFS_W-1:0] OFS_STAT  = 12'h100;
    localparam logic [OFS_W-1:0] OFS_CLEAR = 12'h108;
    localparam logic [OFS_W-1:0] OFS_MASK  = 12'h110;

    localparam logic [MODE_W-1:0] MODE_RESET = 4'h1;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_LEVEL = 2'd1,
        ST_FIRE  = 2'd2,
        ST_HOLD  = 2'd3
    } irq_state_t;

    function automatic logic [STAT_W-1:0] spread_src(input logic [NUM_SRC-1:0] p);
        logic [STAT_W-1:0] v;
        v = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            v[SRC_POS[s]] = p[s];
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    input  logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] enable,
    output logic [STAT_W-1:0] clr_vec,
    output logic              wired,
    output logic              rsp_valid,
    output logic [REG_W-1:0]  rsp_rdata
);

    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

    logic              wr_en;
    logic              rd_en;
    logic              hit_mode;
    logic              hit_stat;
    logic              hit_clear;
    logic              hit_mask;
    logic [MODE_W-1:0] mode_q;
    logic [STAT_W-1:0] enable_q;
    logic [REG_W-1:0]  rd_mux;

    assign wr_en     = req_valid &  req_write;
    assign rd_en     = req_valid & ~req_write;
    assign hit_mode  = (req_addr == A_MODE);
    assign hit_stat  = (req_addr == A_STAT);
    assign hit_clear = (req_addr == A_CLEAR);
    assign hit_mask  = (req_addr == A_MASK);

    // Write-one-to-clear strobe, limited to live bits.
    assign clr_vec = (wr_en && hit_clear) ? (req_wdata & LIVE_MASK) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_RESET;
            enable_q <= '0;
        end else if (wr_en) begin
            if (hit_mode) begin
                mode_q <= req_wdata[MODE_W-1:0];
            end
            if (hit_mask) begin
                enable_q <= req_wdata & LIVE_MASK;
            end
        end
    end

    assign enable = enable_q;
    assign wired  = mode_q[0];

    always_comb begin
        rd_mux = '0;
        if (hit_mode) begin
            rd_mux = REG_W'(mode_q);
        end else if (hit_stat) begin
            rd_mux = status;
        end else if (hit_mask) begin
            rd_mux = enable_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic [STAT_W-1:0]  clr_vec,
    output logic [STAT_W-1:0]  set_vec,
    output logic [STAT_W-1:0]  status
);

    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] status_d;

    assign set_vec = spread_src(src_pulse);

    // Set has priority over a same-cycle clear; dead positions stay zero.
    assign status_d = ((status_q & ~clr_vec) | set_vec) & LIVE_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status = status_q;

endmodule

// File: rtl/irq_agg_outgen.sv
module irq_agg_outgen
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] cause,
    input  logic              wired,
    output logic              irq_level,
    output logic              msg_pulse,
    output logic              err_active
);

    irq_state_t state_q;
    irq_state_t state_d;
    logic       any_cause;
    logic       any_fault;
    logic       fault_q;

    assign any_cause = |cause;
    assign any_fault = |(cause & FAULT_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= any_fault;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (any_cause) begin
                    state_d = wired ? ST_LEVEL : ST_FIRE;
                end
            end
            ST_LEVEL: begin
                if (!any_cause) begin
                    state_d = ST_QUIET;
                end else if (!wired) begin
                    state_d = ST_HOLD;
                end
            end
            ST_FIRE, ST_HOLD: begin
                if (!any_cause) begin
                    state_d = ST_QUIET;
                end else if (wired) begin
                    state_d = ST_LEVEL;
                end else begin
                    state_d = ST_HOLD;
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq_level = 1'b0;
        msg_pulse = 1'b0;
        unique case (state_q)
            ST_LEVEL: irq_level = 1'b1;
            ST_FIRE:  msg_pulse = 1'b1;
            ST_QUIET, ST_HOLD: begin
                irq_level = 1'b0;
                msg_pulse = 1'b0;
            end
            default: begin
                irq_level = 1'b0;
                msg_pulse = 1'b0;
            end
        endcase
    end

    assign err_active = fault_q;

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [REG_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic [REG_W-1:0]   rsp_rdata,
    output logic               irq_level,
    output logic               msg_pulse,
    output logic               err_active
);

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] enable;
    logic [STAT_W-1:0] cause;
    logic              wired;

    irq_agg_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .status    (status),
        .enable    (enable),
        .clr_vec   (clr_vec),
        .wired     (wired),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    irq_agg_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .clr_vec   (clr_vec),
        .set_vec   (set_vec),
        .status    (status)
    );

    assign cause = status & enable;

    irq_agg_outgen u_outgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause      (cause),
        .wired      (wired),
        .irq_level  (irq_level),
        .msg_pulse  (msg_pulse),
        .err_active (err_active)
    );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] set_vec,
    input logic [STAT_W-1:0] clr_vec,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] cause,
    input logic              wired,
    input logic              irq_level,
    input logic              msg_pulse,
    input logic              err_active
);

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status & $past(set_vec)) == $past(set_vec)));

    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status & $past(clr_vec & ~set_vec)) == '0));

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & clr_vec)) |=> ((status & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

    assert_dead_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~LIVE_MASK) == '0);

    assert_level_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_level == ($past(wired) && $past(|cause))));

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |=> !msg_pulse);

    assert_modes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_pulse && irq_level));

    assert_fault_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (err_active == $past(|(cause & FAULT_MASK))));

endmodule

bind dma_irq_agg irq_agg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .status     (status),
    .cause      (cause),
    .wired      (wired),
    .irq_level  (irq_level),
    .msg_pulse  (msg_pulse),
    .err_active (err_active)
);

// File: tb/sim_dma_irq_agg.sv
`timescale 1ns/1ps
module sim_dma_irq_agg;

    localparam logic [11:0] A_MODE  = 12'h004;
    localparam logic [11:0] A_STAT  = 12'h100;
    localparam logic [11:0] A_CLEAR = 12'h108;
    localparam logic [11:0] A_MASK  = 12'h110;

    typedef struct packed {
        logic [5:0]  src;
        logic [15:0] en;
        logic [15:0] st;
        logic        irq;
        logic        err;
    } vec_t;

    // R2 source mapping, R8 fault flag, R11 masking, R5 dead bits
    localparam vec_t VECS [9] = '{
        '{6'h01, 16'h4E03, 16'h0001, 1'b1, 1'b0},
        '{6'h02, 16'h4E03, 16'h0002, 1'b1, 1'b1},
        '{6'h04, 16'h4E03, 16'h0200, 1'b1, 1'b1},
        '{6'h08, 16'h4E03, 16'h0400, 1'b1, 1'b1},
        '{6'h10, 16'h4E03, 16'h0800, 1'b1, 1'b1},
        '{6'h20, 16'h4E03, 16'h4000, 1'b1, 1'b1},
        '{6'h21, 16'h0001, 16'h4001, 1'b1, 1'b0},
        '{6'h3F, 16'h0000, 16'h4E03, 1'b0, 1'b0},
        '{6'h00, 16'hFFFF, 16'h0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src_pulse = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        irq_level;
    logic        msg_pulse;
    logic        err_active;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dma_irq_agg u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_pulse  (src_pulse),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .irq_level  (irq_level),
        .msg_pulse  (msg_pulse),
        .err_active (err_active)
    );

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
        v = rsp_valid;
    endtask

    task automatic fire(input logic [5:0] s);
        @(negedge clk);
        src_pulse = s;
        @(negedge clk);
        src_pulse = '0;
    endtask

    initial begin
        #500000;
        n_fail++;
        n_checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic v;
        int pulses;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "irq_level", 16'(irq_level), 16'h0);
        check("R1", "msg_pulse", 16'(msg_pulse), 16'h0);
        check("R1", "err_active", 16'(err_active), 16'h0);
        bus_rd(A_STAT, d, v);  check("R1", "status", d, 16'h0000);
        bus_rd(A_MASK, d, v);  check("R1", "enable", d, 16'h0000);
        bus_rd(A_MODE, d, v);  check("R1", "mode", d, 16'h0001);

        // Vector table, wired mode
        foreach (VECS[i]) begin
            bus_wr(A_MASK, VECS[i].en);
            bus_wr(A_CLEAR, 16'hFFFF);
            fire(VECS[i].src);
            @(negedge clk);
            check("R6", $sformatf("vec%0d irq_level", i), 16'(irq_level), 16'(VECS[i].irq));
            check("R8", $sformatf("vec%0d err_active", i), 16'(err_active), 16'(VECS[i].err));
            bus_rd(A_STAT, d, v);
            check("R2", $sformatf("vec%0d status", i), d, VECS[i].st);
        end

        // R5 enable stores only live bits (last vector wrote 0xFFFF)
        bus_rd(A_MASK, d, v);
        check("R5", "enable readback", d, 16'h4E03);

        // R3 write-one-to-clear, zero writes no effect, clear reads zero
        bus_wr(A_CLEAR, 16'hFFFF);
        fire(6'h05);
        bus_wr(A_CLEAR, 16'h0001);
        bus_rd(A_STAT, d, v);  check("R3", "partial clear", d, 16'h0200);
        bus_wr(A_CLEAR, 16'h0000);
        bus_rd(A_STAT, d, v);  check("R3", "zero clear", d, 16'h0200);
        bus_rd(A_CLEAR, d, v); check("R3", "clear readback", d, 16'h0000);

        // R4 set wins over same-cycle clear
        bus_wr(A_CLEAR, 16'hFFFF);
        @(negedge clk);
        src_pulse = 6'h01;
        req_valid = 1'b1; req_write = 1'b1; req_addr = A_CLEAR; req_wdata = 16'h0001;
        @(negedge clk);
        src_pulse = '0; req_valid = 1'b0; req_write = 1'b0;
        bus_rd(A_STAT, d, v);  check("R4", "collision status", d, 16'h0001);

        // R6 level drop timing after clear
        bus_wr(A_MASK, 16'h0001);
        @(negedge clk);
        check("R6", "level held", 16'(irq_level), 16'h1);
        bus_wr(A_CLEAR, 16'h0001);
        check("R6", "level one edge after clear", 16'(irq_level), 16'h1);
        @(negedge clk);
        check("R6", "level two edges after clear", 16'(irq_level), 16'h0);

        // R9 mode register
        bus_wr(A_MODE, 16'hFFF6);
        bus_rd(A_MODE, d, v);  check("R9", "mode readback", d, 16'h0006);

        // R7 message mode
        bus_wr(A_MODE, 16'h0000);
        bus_wr(A_CLEAR, 16'hFFFF);
        bus_wr(A_MASK, 16'h4E03);
        fire(6'h01);
        check("R7", "msg before edge", 16'(msg_pulse), 16'h0);
        @(negedge clk);
        check("R7", "msg pulse", 16'(msg_pulse), 16'h1);
        check("R7", "no level in msg mode", 16'(irq_level), 16'h0);
        @(negedge clk);
        check("R7", "msg one cycle", 16'(msg_pulse), 16'h0);
        pulses = 0;
        fire(6'h04);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pulses += int'(msg_pulse);
        end
        check("R7", "no pulse while cause held", 16'(pulses), 16'h0);
        check("R8", "fault in msg mode", 16'(err_active), 16'h1);
        bus_wr(A_CLEAR, 16'hFFFF);
        repeat (2) @(negedge clk);
        check("R8", "fault gone after clear", 16'(err_active), 16'h0);
        fire(6'h02);
        @(negedge clk);
        check("R7", "fresh cause pulses again", 16'(msg_pulse), 16'h1);

        // R10 unmapped read and response timing
        bus_rd(12'h200, d, v);
        check("R10", "unmapped data", d, 16'h0000);
        check("R10", "rsp_valid", 16'(v), 16'h1);
        @(negedge clk);
        check("R10", "rsp_valid drops", 16'(rsp_valid), 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule